// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central issue controller of a single-issue, dynamically scheduled core. It has five non-pipelined functional units. Each cycle it takes one decoded instruction: an opcode, a destination, two source registers and a unit class. It decides whether that instruction may enter a unit now. For each unit that holds an instruction, it decides when the unit may read its operands and when it may write its result back to the register file. Each unit reports the end of its execution with a one-cycle done pulse.

Every instruction passes through four phases: issue, operand read, execute and result write. Only issue happens in program order. The controller keeps one status entry per unit. An entry holds the busy flag, the opcode, the destination, both sources, the unit that will produce each source, and a ready flag per source. A per-register table records which unit will write each register next. Producers are named by unit id. Unit ids are Integer 0, Mult1 1, Mult2 2, Add 3 and Divide 4.

The stall rules are these. A write-after-write hazard stalls at issue. A read-after-write hazard holds the operand read. A write-after-read hazard holds the result write.

Top module: `sb_hazard_ctl`

## Requirements
- R1: After reset every unit is free, `rd_grant` and `wr_grant` are zero, and `issue_ok` is low while `in_valid` is low.
- R2: Class codes map to units as follows: 0 to Integer (id 0), 2 to Add (id 3) and 3 to Divide (id 4). Class 1 goes to Mult1 (id 1) when it is free, otherwise to Mult2 (id 2). `issue_ok` is combinational in the cycle `in_valid` is presented. It is low while the selected unit is busy, and `issue_unit` gives the selected id.
- R3: An instruction whose destination already has a pending writer in the register table is not issued until the cycle after that writer's write grant.
- R4: A unit gets a one-cycle `rd_grant` when neither of its sources waits on a producing unit. The earliest this can happen is the cycle after issue. A unit never gets a read and a write grant together, and a free unit gets neither.
- R5: When a unit is granted a write, every entry waiting on that unit stops waiting, so a consumer may read in the next cycle. An instruction issued in that same write cycle treats that source as already available.
- R6: A unit that has finished executing is held from writing while any other busy unit still has that register as an unread, ready source. It writes in the cycle after that source is read.
- R7: At most one `wr_grant` bit is set per cycle, and the lowest unit id wins. `wr_reg` carries the granted unit's destination.
- R8: A `done` bit is ignored unless its unit is executing. A done pulse while the unit is executing makes the unit eligible to write from the next cycle.
- R9: While a unit is busy, `unit_op` slice [u*OPW +: OPW] holds the opcode of the instruction issued to unit u.
- R10: A write grant frees the unit and clears the register table entry if it still names that unit, so the unit accepts a new issue in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is offered |
| in_op | input | OPW | Opcode of the offered instruction |
| in_cls | input | 2 | Unit class: 0 integer, 1 multiply, 2 add, 3 divide |
| in_dst | input | log2(NREG) | Destination register |
| in_src1 | input | log2(NREG) | First source register |
| in_src2 | input | log2(NREG) | Second source register |
| done | input | 5 | Per-unit execution-finished pulse |
| issue_ok | output | 1 | The offered instruction is accepted this cycle |
| issue_unit | output | 3 | Unit chosen for the offered instruction |
| rd_grant | output | 5 | Per-unit operand-read grant |
| wr_grant | output | 5 | Per-unit result-write grant, at most one bit set |
| wr_reg | output | log2(NREG) | Register written under `wr_grant` |
| unit_op | output | 5*OPW | Opcode held by each unit |

## Verification
The cycle in which each result is due is fixed. `issue_ok` and `issue_unit` answer in the same cycle the instruction is offered. A read grant comes no earlier than the cycle after issue, and one cycle after the write that wakes the consumer. A write grant comes no earlier than the cycle after the done pulse, and one cycle after a blocking reader's grant.

The bench drives inputs just after the falling edge and samples all outputs 1 ns later, in the same cycle. A behavioural model updated at the same point predicts every output each cycle. Directed sequences then compare the logged cycle numbers of issue, read and write against the offsets stated in the requirements.

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl #(
  parameter int NREG = 32,
  parameter int OPW  = 4,
  localparam int RW = $clog2(NREG),
  localparam int NU = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPW-1:0]    in_op,
  input  logic [1:0]        in_cls,
  input  logic [RW-1:0]     in_dst,
  input  logic [RW-1:0]     in_src1,
  input  logic [RW-1:0]     in_src2,
  input  logic [NU-1:0]     done,
  output logic              issue_ok,
  output logic [2:0]        issue_unit,
  output logic [NU-1:0]     rd_grant,
  output logic [NU-1:0]     wr_grant,
  output logic [RW-1:0]     wr_reg,
  output logic [NU*OPW-1:0] unit_op
);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_RD = 2'd1, PH_EX = 2'd2, PH_WR = 2'd3;

  logic [NU-1:0]  busy, rj, rk, cand, sel_oh;
  logic [1:0]     ph    [NU];
  logic [OPW-1:0] op_q  [NU];
  logic [RW-1:0]  fi    [NU];
  logic [RW-1:0]  fj    [NU];
  logic [RW-1:0]  fk    [NU];
  logic [2:0]     qj    [NU];
  logic [2:0]     qk    [NU];
  logic [2:0]     rstat [NREG];
  logic [2:0]     wr_tag, qs1, qs2;

  always_comb begin
    case (in_cls)
      2'd0:    issue_unit = 3'd0;
      2'd1:    issue_unit = busy[1] ? 3'd2 : 3'd1;
      2'd2:    issue_unit = 3'd3;
      default: issue_unit = 3'd4;
    endcase
  end

  assign sel_oh   = NU'(1) << issue_unit;
  assign issue_ok = in_valid && ((busy & sel_oh) == '0) && (rstat[in_dst] == 3'd0);

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic blk;
    always_comb begin
      blk = 1'b0;
      for (int v = 0; v < NU; v++)
        if (v != u && busy[v] &&
            ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
          blk = 1'b1;
    end
    assign rd_grant[u] = (ph[u] == PH_RD) && rj[u] && rk[u];
    assign cand[u]     = (ph[u] == PH_WR) && !blk;
    assign unit_op[u*OPW +: OPW] = op_q[u];
  end

  assign wr_grant = cand & (~cand + NU'(1));

  always_comb begin
    wr_tag = 3'd0;
    wr_reg = '0;
    for (int u = NU-1; u >= 0; u--)
      if (cand[u]) begin
        wr_tag = 3'(u + 1);
        wr_reg = fi[u];
      end
  end

  assign qs1 = (rstat[in_src1] == wr_tag) ? 3'd0 : rstat[in_src1];
  assign qs2 = (rstat[in_src2] == wr_tag) ? 3'd0 : rstat[in_src2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      rj   <= '0;
      rk   <= '0;
      for (int u = 0; u < NU; u++) begin
        ph[u]   <= PH_IDLE;
        op_q[u] <= '0;
        fi[u]   <= '0;
        fj[u]   <= '0;
        fk[u]   <= '0;
        qj[u]   <= 3'd0;
        qk[u]   <= 3'd0;
      end
      for (int r = 0; r < NREG; r++) rstat[r] <= 3'd0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (wr_grant[u]) begin
          busy[u] <= 1'b0;
          ph[u]   <= PH_IDLE;
        end else if (issue_ok && issue_unit == 3'(u)) begin
          busy[u] <= 1'b1;
          ph[u]   <= PH_RD;
          op_q[u] <= in_op;
          fi[u]   <= in_dst;
          fj[u]   <= in_src1;
          fk[u]   <= in_src2;
          qj[u]   <= qs1;
          qk[u]   <= qs2;
          rj[u]   <= (qs1 == 3'd0);
          rk[u]   <= (qs2 == 3'd0);
        end else if (rd_grant[u]) begin
          ph[u] <= PH_EX;
          rj[u] <= 1'b0;
          rk[u] <= 1'b0;
        end else begin
          if (ph[u] == PH_EX && done[u]) ph[u] <= PH_WR;
          if (wr_tag != 3'd0 && qj[u] == wr_tag) begin
            qj[u] <= 3'd0;
            rj[u] <= 1'b1;
          end
          if (wr_tag != 3'd0 && qk[u] == wr_tag) begin
            qk[u] <= 3'd0;
            rk[u] <= 1'b1;
          end
        end
      end
      for (int r = 0; r < NREG; r++) begin
        if (issue_ok && in_dst == RW'(r))
          rstat[r] <= issue_unit + 3'd1;
        else if (wr_tag != 3'd0 && wr_reg == RW'(r) && rstat[r] == wr_tag)
          rstat[r] <= 3'd0;
      end
    end
  end
endmodule

// File: rtl/sb_hazard_ctl_chk.sv
module sb_hazard_ctl_chk #(
  parameter int NU = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_ok,
  input logic [2:0]    issue_unit,
  input logic [NU-1:0] busy,
  input logic [NU-1:0] rd_grant,
  input logic [NU-1:0] wr_grant
);
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant)); // R7

  AST_RD_WR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant & wr_grant) == '0); // R4

  AST_GRANT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_grant | wr_grant) & ~busy) == '0); // R4

  AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |=> (busy & (NU'(1) << $past(issue_unit))) != '0); // R2

  AST_WRITE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant != '0) |=> (busy & $past(wr_grant)) == '0); // R10
endmodule

bind sb_hazard_ctl sb_hazard_ctl_chk #(.NU(5)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_ok(issue_ok), .issue_unit(issue_unit),
  .busy(busy), .rd_grant(rd_grant), .wr_grant(wr_grant)
);

// File: tb/tb_sb_hazard_ctl.sv
`timescale 1ns/1ps
module tb_sb_hazard_ctl;
  localparam int NU = 5, NREG = 32, RW = 5, OPW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_valid = 1'b0;
  logic [OPW-1:0]    in_op = '0;
  logic [1:0]        in_cls = '0;
  logic [RW-1:0]     in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NU-1:0]     done = '0;
  logic              issue_ok;
  logic [2:0]        issue_unit;
  logic [NU-1:0]     rd_grant, wr_grant;
  logic [RW-1:0]     wr_reg;
  logic [NU*OPW-1:0] unit_op;

  sb_hazard_ctl #(.NREG(NREG), .OPW(OPW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_cls(in_cls),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .done(done),
    .issue_ok(issue_ok), .issue_unit(issue_unit), .rd_grant(rd_grant),
    .wr_grant(wr_grant), .wr_reg(wr_reg), .unit_op(unit_op));

  typedef struct { int op; int cls; int dst; int s1; int s2; } ins_t;
  ins_t iq[$];

  int tests = 0, fails = 0, cyc = 0, n_iss = 0;
  bit finished = 0;
  int lat [NU] = '{3, 10, 10, 2, 12};
  int m_busy[NU], m_ph[NU], m_op[NU], m_fi[NU], m_fj[NU], m_fk[NU], m_qj[NU], m_qk[NU], m_cnt[NU];
  int m_rs[NREG];
  int iss_c[128], rd_c[128], wr_c[128], unit_of[128], cur_inst[NU];
  logic [NU-1:0] spur = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int cls, input int dst, input int s1, input int s2);
    ins_t t;
    t.op = (dst * 3 + s1 + cls) & 15; t.cls = cls; t.dst = dst; t.s1 = s1; t.s2 = s2;
    iq.push_back(t);
  endtask

  function automatic bit model_idle();
    for (int u = 0; u < NU; u++) if (m_busy[u] != 0) return 0;
    return iq.size() == 0;
  endfunction

  task automatic step();
    ins_t h;
    int sel, w, q1, q2;
    bit e_iss, blk;
    logic [NU-1:0] e_rd, e_wr;
    @(negedge clk);
    cyc++;
    if (iq.size() > 0) begin
      h = iq[0];
      in_valid = 1'b1; in_op = OPW'(h.op); in_cls = 2'(h.cls);
      in_dst = RW'(h.dst); in_src1 = RW'(h.s1); in_src2 = RW'(h.s2);
    end else begin
      h = '{0, 0, 0, 0, 0};
      in_valid = 1'b0;
    end
    for (int u = 0; u < NU; u++) done[u] = (m_ph[u] == 2 && m_cnt[u] == 0) || spur[u];
    #1;
    case (h.cls)
      0: sel = 0;
      1: sel = m_busy[1] ? 2 : 1;
      2: sel = 3;
      default: sel = 4;
    endcase
    e_iss = in_valid && m_busy[sel] == 0 && m_rs[h.dst] < 0;
    e_rd = '0; e_wr = '0; w = -1;
    for (int u = 0; u < NU; u++) begin
      e_rd[u] = m_ph[u] == 1 && m_qj[u] < 0 && m_qk[u] < 0;
      if (m_ph[u] == 3 && w < 0) begin
        blk = 0;
        for (int v = 0; v < NU; v++)
          if (v != u && m_ph[v] == 1 &&
              ((m_qj[v] < 0 && m_fj[v] == m_fi[u]) || (m_qk[v] < 0 && m_fk[v] == m_fi[u])))
            blk = 1;
        if (!blk) w = u;
      end
    end
    if (w >= 0) e_wr[w] = 1'b1;
    chk(issue_ok == e_iss, (in_valid && m_busy[sel] == 0 && m_rs[h.dst] >= 0) ? "R3 issue" : "R2 issue",
        int'(issue_ok), int'(e_iss));
    if (e_iss) chk(int'(issue_unit) == sel, "R2 unit", int'(issue_unit), sel);
    chk(rd_grant == e_rd, "R4 read grant", int'(rd_grant), int'(e_rd));
    chk(wr_grant == e_wr, "R7 write grant", int'(wr_grant), int'(e_wr));
    if (w >= 0) chk(int'(wr_reg) == m_fi[w], "R7 write reg", int'(wr_reg), m_fi[w]);
    for (int u = 0; u < NU; u++)
      if (m_busy[u] != 0)
        chk(int'(unit_op[u*OPW +: OPW]) == m_op[u], "R9 unit op", int'(unit_op[u*OPW +: OPW]), m_op[u]);
    for (int u = 0; u < NU; u++) begin
      if (rd_grant[u]) rd_c[cur_inst[u]] = cyc;
      if (wr_grant[u]) wr_c[cur_inst[u]] = cyc;
    end
    if (issue_ok && n_iss < 128) begin
      iss_c[n_iss] = cyc; unit_of[n_iss] = int'(issue_unit);
      cur_inst[issue_unit] = n_iss; n_iss++;
    end
    q1 = m_rs[h.s1]; if (w >= 0 && q1 == w) q1 = -1;
    q2 = m_rs[h.s2]; if (w >= 0 && q2 == w) q2 = -1;
    for (int u = 0; u < NU; u++) begin
      if (m_ph[u] == 2) begin
        if (done[u]) m_ph[u] = 3; else if (m_cnt[u] > 0) m_cnt[u]--;
      end else if (m_ph[u] == 1 && e_rd[u]) begin
        m_ph[u] = 2; m_cnt[u] = lat[u] - 1;
      end
    end
    if (w >= 0) begin
      for (int v = 0; v < NU; v++) begin
        if (m_qj[v] == w) m_qj[v] = -1;
        if (m_qk[v] == w) m_qk[v] = -1;
      end
      if (m_rs[m_fi[w]] == w) m_rs[m_fi[w]] = -1;
      m_busy[w] = 0; m_ph[w] = 0;
    end
    if (e_iss) begin
      m_busy[sel] = 1; m_ph[sel] = 1; m_op[sel] = h.op;
      m_fi[sel] = h.dst; m_fj[sel] = h.s1; m_fk[sel] = h.s2;
      m_qj[sel] = q1; m_qk[sel] = q2;
      m_rs[h.dst] = sel;
      void'(iq.pop_front());
    end
  endtask

  task automatic run_idle(input int cap);
    for (int i = 0; i < cap && !model_idle(); i++) step();
    step();
  endtask

  initial begin
    #750000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (R1..R10 unfinished): actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b;
    for (int u = 0; u < NU; u++) begin
      m_busy[u] = 0; m_ph[u] = 0; m_qj[u] = -1; m_qk[u] = -1; m_cnt[u] = 0; cur_inst[u] = 0;
    end
    for (int r = 0; r < NREG; r++) m_rs[r] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(issue_ok == 1'b0, "R1 reset issue", int'(issue_ok), 0);
    chk(rd_grant == '0, "R1 reset read", int'(rd_grant), 0);
    chk(wr_grant == '0, "R1 reset write", int'(wr_grant), 0);

    // classic dependence chain
    b = n_iss;
    push(0, 6, 2, 0); push(0, 2, 3, 0); push(1, 0, 2, 4);
    push(2, 8, 6, 2); push(3, 10, 0, 6); push(2, 6, 8, 2);
    run_idle(400);
    chk(iss_c[b] == 1, "R1 first issue cycle", iss_c[b], 1);
    chk(iss_c[b+1] == wr_c[b] + 1, "R2 busy unit stall", iss_c[b+1], wr_c[b] + 1);
    chk(unit_of[b+2] == 1, "R2 first multiply unit", unit_of[b+2], 1);
    chk(rd_c[b+2] == wr_c[b+1] + 1, "R5 wakeup read", rd_c[b+2], wr_c[b+1] + 1);
    chk(wr_c[b+5] == rd_c[b+4] + 1, "R6 write after read hold", wr_c[b+5], rd_c[b+4] + 1);
    chk(iss_c[b+5] == wr_c[b+3] + 1, "R10 unit reuse", iss_c[b+5], wr_c[b+3] + 1);

    // simultaneous write candidates
    b = n_iss;
    push(0, 20, 21, 22); push(2, 23, 24, 25);
    run_idle(100);
    chk(rd_c[b] == iss_c[b] + 1, "R4 earliest read", rd_c[b], iss_c[b] + 1);
    chk(wr_c[b+1] == wr_c[b] + 1, "R7 lowest id first", wr_c[b+1], wr_c[b] + 1);
    chk(wr_c[b] == rd_c[b] + lat[0] + 1, "R8 done to write", wr_c[b], rd_c[b] + lat[0] + 1);

    // write-after-write
    b = n_iss;
    push(2, 7, 1, 1); push(0, 7, 2, 3);
    run_idle(100);
    chk(iss_c[b+1] == wr_c[b] + 1, "R3 waw stall", iss_c[b+1], wr_c[b] + 1);

    // two multiplies share the class
    b = n_iss;
    push(1, 26, 1, 2); push(1, 27, 3, 4); push(1, 28, 5, 6);
    run_idle(200);
    chk(unit_of[b+1] == 2, "R2 second multiply unit", unit_of[b+1], 2);
    chk(iss_c[b+2] == wr_c[b] + 1, "R2 both multiplies busy", iss_c[b+2], wr_c[b] + 1);

    // stray done pulses
    spur = '1;
    step();
    spur = '0;
    step();
    chk(wr_grant == '0, "R8 stray done idle", int'(wr_grant), 0);
    b = n_iss;
    push(1, 18, 1, 1); push(3, 19, 18, 1);
    repeat (4) step();
    spur = 5'b10000;
    step();
    spur = '0;
    run_idle(200);
    chk(wr_c[b+1] == rd_c[b+1] + lat[4] + 1, "R8 stray done waiting", wr_c[b+1], rd_c[b+1] + lat[4] + 1);

    // mixed stream over a small register set
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(int'(lfsr[1:0]), int'(lfsr[4:2]), int'(lfsr[7:5]), int'(lfsr[10:8]));
    end
    run_idle(3000);
    chk(iq.size() == 0, "R10 stream drained", iq.size(), 0);
    chk(model_idle() && rd_grant == '0 && wr_grant == '0, "R10 all units free", int'(wr_grant), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule